// File: doc/BRIEF.md
# Sequential First-Touch Frame Allocator

This block gives out physical page frame numbers. It places them so that a workload occupies as few memory devices as possible, and the power manager can then keep every device that has never been touched in its deepest low-power state. Physical memory is split into `NUM_DEV` devices with `FRAMES_PER_DEV` frames each. Addresses are not interleaved, so device k owns one contiguous span of frame numbers. Each device has its own fill counter, and inside a device the frames are always handed out in ascending order.

A requester sends a request and a placement mode. In packing mode the block uses the lowest-numbered device that still has room, so device 0 fills completely before device 1 gets its first frame. Two other modes exist for comparison. Round-robin mode spreads consecutive pages across the devices, one page per device in turn. Random mode picks the device from a pseudo-random sequence. The top `RESV_FRAMES` frames of device 0 are set aside as a landing area for a later page migration, and no mode ever hands them out. Each allocation result carries its frame number and device index. The block also keeps a sticky per-device "touched" flag and raises an exhausted flag once no usable frame is left.

Top module: `frame_alloc`

## Requirements
- R1: After reset, `allocValid` is 0, `devInUse` is all zeros, `outOfMem` is 0 and `reqReady` is 1.
- R2: A request is accepted on a rising edge where both `reqValid` and `reqReady` are 1. Exactly one cycle later `allocValid` is 1 for one cycle, with that request's result. In every other cycle `allocValid` is 0.
- R3: `mode` 0 (packing), and the unused code 3, which behaves the same way, both pick the lowest-numbered device that is not full. Across a run, the frames returned therefore ascend, and a device is full before the next device receives anything.
- R4: Device k owns frames k*FRAMES_PER_DEV to k*FRAMES_PER_DEV+FRAMES_PER_DEV-1. Within a device, frames are returned in ascending offset order starting at offset 0. `allocDev` equals `allocFrame / FRAMES_PER_DEV`.
- R5: Frames at offsets FRAMES_PER_DEV-RESV_FRAMES to FRAMES_PER_DEV-1 of device 0 are never returned, so device 0 counts as full after FRAMES_PER_DEV-RESV_FRAMES allocations.
- R6: `mode` 1 (round-robin) starts the search at a turn pointer and takes the first device that is not full, going upward and wrapping. After each round-robin grant, the pointer moves to the granted device plus one, modulo NUM_DEV. The pointer is 0 after reset and changes only on round-robin grants.
- R7: `mode` 2 (random) starts the same upward, wrapping search at the low log2(NUM_DEV) bits of an 8-bit register. That register is 0x01 after reset. On each random-mode grant it shifts left, taking in bit7^bit5^bit4^bit3 as its new bit 0.
- R8: `devInUse[k]` rises together with the `allocValid` of the first frame returned from device k, and stays high until reset.
- R9: `outOfMem` is 1 exactly when every device is full. While it is 1, `reqReady` is 0 and requests produce no `allocValid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Allocation request |
| mode | input | 2 | Placement mode: 0 packing, 1 round-robin, 2 random, 3 as 0 |
| reqReady | output | 1 | Request can be accepted |
| allocValid | output | 1 | Result valid this cycle |
| allocFrame | output | $clog2(NUM_DEV*FRAMES_PER_DEV) | Granted frame number |
| allocDev | output | $clog2(NUM_DEV) | Device holding the granted frame |
| devInUse | output | NUM_DEV | Per-device touched flag |
| outOfMem | output | 1 | All usable frames allocated |

## Verification
The hardest situation to reach is a search that has to skip full devices, in round-robin and random mode, while only some of the devices are full. Reaching it needs long runs that switch between modes. The stimulus first fills devices unevenly in packing mode. It then runs round-robin and random phases with random request gaps and occasional mode changes, and finally forces exhaustion, so the pointer and the pseudo-random register both arrive at full devices many times. A bench model of the pointer, the shift register and the fill counters predicts every result.

// File: rtl/frame_alloc_pkg.sv
package frame_alloc_pkg;

  typedef enum logic [1:0] {
    MODE_PACK = 2'd0,
    MODE_RR   = 2'd1,
    MODE_RAND = 2'd2,
    MODE_ALT  = 2'd3
  } place_mode_e;

  typedef struct packed {
    logic grant;
    logic advTurn;
    logic advLfsr;
  } alloc_strobe_t;

endpackage

// File: rtl/frame_alloc_ctrl.sv
module frame_alloc_ctrl
  import frame_alloc_pkg::*;
#(
  parameter int NUM_DEV = 4,
  localparam int DEV_W = $clog2(NUM_DEV)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reqValid,
  input  place_mode_e        mode,
  input  logic [NUM_DEV-1:0] devFull,
  input  logic [DEV_W-1:0]   turnPtr,
  input  logic [DEV_W-1:0]   randPick,
  output logic [DEV_W-1:0]   devSel,
  output alloc_strobe_t      strobe
);

  logic [DEV_W-1:0] startDev;
  logic             found;

  always_comb begin
    unique case (mode)
      MODE_RR:   startDev = turnPtr;
      MODE_RAND: startDev = randPick;
      default:   startDev = '0;
    endcase
  end

  always_comb begin
    devSel = startDev;
    found  = 1'b0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (!found && !devFull[startDev + DEV_W'(i)]) begin
        devSel = startDev + DEV_W'(i);
        found  = 1'b1;
      end
    end
  end

  always_comb begin
    strobe.grant   = reqValid && found;
    strobe.advTurn = reqValid && found && (mode == MODE_RR);
    strobe.advLfsr = reqValid && found && (mode == MODE_RAND);
  end

  // In packing mode every lower device must already be full.
  p_pack_lowest_r3: assert property (@(posedge clk) disable iff (rst)
    (strobe.grant && (mode == MODE_PACK || mode == MODE_ALT)) |->
      ((devFull & ((NUM_DEV'(1) << devSel) - NUM_DEV'(1))) ==
       ((NUM_DEV'(1) << devSel) - NUM_DEV'(1))));

endmodule

// File: rtl/frame_alloc_data.sv
module frame_alloc_data
  import frame_alloc_pkg::*;
#(
  parameter int NUM_DEV        = 4,
  parameter int FRAMES_PER_DEV = 16,
  parameter int RESV_FRAMES    = 4,
  localparam int DEV_W = $clog2(NUM_DEV),
  localparam int OFF_W = $clog2(FRAMES_PER_DEV),
  localparam int CNT_W = OFF_W + 1,
  localparam int FR_W  = DEV_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reqValid,
  input  logic [DEV_W-1:0]   devSel,
  input  alloc_strobe_t      strobe,
  output logic [NUM_DEV-1:0] devFull,
  output logic [DEV_W-1:0]   turnPtr,
  output logic [DEV_W-1:0]   randPick,
  output logic               allocValid,
  output logic [FR_W-1:0]    allocFrame,
  output logic [DEV_W-1:0]   allocDev,
  output logic [NUM_DEV-1:0] devInUse,
  output logic               outOfMem,
  output logic               reqReady
);

  logic [CNT_W-1:0] fillCnt [NUM_DEV];
  logic [7:0]       lfsr;

  for (genvar k = 0; k < NUM_DEV; k++) begin : g_dev
    localparam int CAP = (k == 0) ? FRAMES_PER_DEV - RESV_FRAMES : FRAMES_PER_DEV;
    assign devFull[k] = (fillCnt[k] == CNT_W'(CAP));

    always_ff @(posedge clk) begin
      if (rst) begin
        fillCnt[k]  <= '0;
        devInUse[k] <= 1'b0;
      end else if (strobe.grant && devSel == DEV_W'(k)) begin
        fillCnt[k]  <= fillCnt[k] + CNT_W'(1);
        devInUse[k] <= 1'b1;
      end
    end

    p_inuse_sticky_r8: assert property (@(posedge clk) disable iff (rst)
      devInUse[k] |=> devInUse[k]);
  end

  assign outOfMem = &devFull;
  assign reqReady = !outOfMem;
  assign randPick = lfsr[DEV_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      turnPtr    <= '0;
      lfsr       <= 8'h01;
      allocValid <= 1'b0;
      allocFrame <= '0;
      allocDev   <= '0;
    end else begin
      allocValid <= strobe.grant;
      if (strobe.grant) begin
        allocDev   <= devSel;
        allocFrame <= {devSel, fillCnt[devSel][OFF_W-1:0]};
      end
      if (strobe.advTurn) turnPtr <= devSel + DEV_W'(1);
      if (strobe.advLfsr) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
  end

  p_resv_skip_r5: assert property (@(posedge clk) disable iff (rst)
    (allocValid && allocDev == '0) |->
      (allocFrame[OFF_W-1:0] < OFF_W'(FRAMES_PER_DEV - RESV_FRAMES)));

  p_exhaust_block_r9: assert property (@(posedge clk) disable iff (rst)
    outOfMem |=> !allocValid);

  p_valid_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
    allocValid |-> $past(reqValid && reqReady));

endmodule

// File: rtl/frame_alloc.sv
module frame_alloc
  import frame_alloc_pkg::*;
#(
  parameter int NUM_DEV        = 4,
  parameter int FRAMES_PER_DEV = 16,
  parameter int RESV_FRAMES    = 4,
  localparam int DEV_W = $clog2(NUM_DEV),
  localparam int FR_W  = $clog2(NUM_DEV * FRAMES_PER_DEV)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reqValid,
  input  logic [1:0]         mode,
  output logic               reqReady,
  output logic               allocValid,
  output logic [FR_W-1:0]    allocFrame,
  output logic [DEV_W-1:0]   allocDev,
  output logic [NUM_DEV-1:0] devInUse,
  output logic               outOfMem
);

  logic [NUM_DEV-1:0] devFull;
  logic [DEV_W-1:0]   turnPtr;
  logic [DEV_W-1:0]   randPick;
  logic [DEV_W-1:0]   devSel;
  alloc_strobe_t      strobe;

  frame_alloc_ctrl #(.NUM_DEV(NUM_DEV)) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .mode     (place_mode_e'(mode)),
    .devFull  (devFull),
    .turnPtr  (turnPtr),
    .randPick (randPick),
    .devSel   (devSel),
    .strobe   (strobe)
  );

  frame_alloc_data #(
    .NUM_DEV        (NUM_DEV),
    .FRAMES_PER_DEV (FRAMES_PER_DEV),
    .RESV_FRAMES    (RESV_FRAMES)
  ) i_data (
    .clk        (clk),
    .rst        (rst),
    .reqValid   (reqValid),
    .devSel     (devSel),
    .strobe     (strobe),
    .devFull    (devFull),
    .turnPtr    (turnPtr),
    .randPick   (randPick),
    .allocValid (allocValid),
    .allocFrame (allocFrame),
    .allocDev   (allocDev),
    .devInUse   (devInUse),
    .outOfMem   (outOfMem),
    .reqReady   (reqReady)
  );

endmodule

// File: tb/test_frame_alloc.sv
module test_frame_alloc;

  localparam int ND   = 4;
  localparam int NF   = 16;
  localparam int NR   = 4;
  localparam int DW   = $clog2(ND);
  localparam int FW   = $clog2(ND * NF);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reqValid = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic          reqReady, allocValid, outOfMem;
  logic [FW-1:0] allocFrame;
  logic [DW-1:0] allocDev;
  logic [ND-1:0] devInUse;

  frame_alloc #(.NUM_DEV(ND), .FRAMES_PER_DEV(NF), .RESV_FRAMES(NR)) i_frame_alloc (
    .clk(clk), .rst(rst), .reqValid(reqValid), .mode(mode), .reqReady(reqReady),
    .allocValid(allocValid), .allocFrame(allocFrame), .allocDev(allocDev),
    .devInUse(devInUse), .outOfMem(outOfMem)
  );

  always #10 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // bench model
  int   mFill [ND];
  int   mTurn;
  bit [7:0] mLfsr;
  bit   expValid;
  int   expFrame, expDev;
  bit [ND-1:0] expInUse;
  string expTag;

  function automatic int capOf(int k);
    return (k == 0) ? NF - NR : NF;
  endfunction

  function automatic bit modelFull(int k);
    return mFill[k] == capOf(k);
  endfunction

  function automatic bit modelOom();
    for (int k = 0; k < ND; k++) if (!modelFull(k)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int searchFrom(int start);
    for (int i = 0; i < ND; i++) if (!modelFull((start + i) % ND)) return (start + i) % ND;
    return -1;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int k = 0; k < ND; k++) mFill[k] = 0;
    mTurn = 0; mLfsr = 8'h01; expValid = 0; expFrame = 0; expDev = 0; expInUse = '0;
  endtask

  // one cycle: called at a negedge
  task automatic step(bit v, bit [1:0] m);
    int d;
    chk(allocValid == expValid, "R2", "allocValid", allocValid, expValid);
    if (expValid && allocValid) begin
      chk(allocFrame == expFrame, expTag, "allocFrame", allocFrame, expFrame);
      chk(allocDev == expDev, "R4", "allocDev", allocDev, expDev);
      chk(allocDev == allocFrame / NF, "R4", "dev vs frame", allocDev, allocFrame / NF);
      if (allocDev == 0)
        chk(allocFrame < NF - NR, "R5", "reserved frame", allocFrame, NF - NR - 1);
    end
    chk(devInUse == expInUse, "R8", "devInUse", devInUse, expInUse);
    chk(outOfMem == modelOom(), "R9", "outOfMem", outOfMem, modelOom());
    chk(reqReady == !modelOom(), "R9", "reqReady", reqReady, !modelOom());
    reqValid = v;
    mode = m;
    expValid = 0;
    if (v && !modelOom()) begin
      case (m)
        2'd1: begin d = searchFrom(mTurn); mTurn = (d + 1) % ND; expTag = "R6"; end
        2'd2: begin
          d = searchFrom(int'(mLfsr[DW-1:0]));
          mLfsr = {mLfsr[6:0], mLfsr[7] ^ mLfsr[5] ^ mLfsr[4] ^ mLfsr[3]};
          expTag = "R7";
        end
        default: begin d = searchFrom(0); expTag = "R3"; end
      endcase
      expValid = 1;
      expDev = d;
      expFrame = d * NF + mFill[d];
      mFill[d]++;
      expInUse[d] = 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1; reqValid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    modelReset();
    chk(allocValid == 0 && devInUse == '0, "R1", "valid/inuse after reset", {allocValid, devInUse}, 0);
    chk(outOfMem == 0 && reqReady == 1, "R1", "oom/ready after reset", {outOfMem, reqReady}, 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    doReset();
    // packing phase, frames must ascend (R3), device 0 stops before reserve (R5)
    for (int i = 0; i < 20; i++) step(($urandom % 4) != 0, 2'd0);
    // round-robin with device 0 full: skipping (R6)
    for (int i = 0; i < 16; i++) step(($urandom % 3) != 0, 2'd1);
    // random mode (R7) with occasional code 3 (R3)
    for (int i = 0; i < 20; i++) step(1'b1, ($urandom % 5 == 0) ? 2'd3 : 2'd2);
    // mixed until exhausted, then requests ignored (R9)
    for (int i = 0; i < 40; i++) step(1'b1, 2'($urandom % 4));
    for (int i = 0; i < 5; i++) step(1'b1, 2'd0);
    chk(outOfMem == 1, "R9", "exhausted flag", outOfMem, 1);
    // directed round-robin from fresh state: frames 0,16,32,48,1,17 (R6)
    doReset();
    for (int i = 0; i < 8; i++) step(1'b1, 2'd1);
    // fresh random run with gaps (R7)
    doReset();
    for (int i = 0; i < 30; i++) step(($urandom % 2) != 0, 2'd2);
    step(1'b0, 2'd0);
    step(1'b0, 2'd0);
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule